// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

The block is a full-duplex asynchronous serial port. One 11-bit control word sets up both directions: the frame format (7 or 8 data bits, no, odd or even parity, 1 or 2 stop bits), transmit enable, loopback, a line-break override and three interrupt enables. Bytes written into a single holding register move to a shift register and go out on `tx_o`. The receiver oversamples its input 16 times per bit. It delivers each completed byte through a data-ready flag, and it records parity, framing, overrun and break conditions in sticky flags.

The baud rate comes from an external enable pulse, `baud_tick_i`, which fires 16 times per bit period. Software-side logic writes the control word with `cfg_we_i` and sends bytes with `tx_wr_i`. It takes received bytes with `rx_rd_i` and clears the error flags with `stat_rd_i`. The three interrupt outputs are levels. Each one stays high for as long as its status condition and its enable bit are both true.

Top module: `uart_port`

## Requirements
- R1: After reset the control word is all zero. `tx_o` is 1, `tx_empty_o` is 1, `rx_ready_o` is 0, `rx_err_o` is 0 and all three interrupt outputs are 0.
- R2: Control bit layout: bit0 transmit enable, bit1 eight data bits (0 gives seven), bit2 two stop bits, bits[4:3] parity (0x none, 10 odd, 11 even), bit5 break, bit6 break level, bit7 loopback, bit8 transmit irq enable, bit9 receive irq enable, bit10 status irq enable. A transmitted frame is one start bit at 0, then the data bits LSB first, then the parity bit when enabled, then the stop bits at 1. Each bit lasts 16 baud ticks.
- R3: While bit0 is 0 no new frame starts, and a byte in the holding register stays there.
- R4: `tx_wr_i` loads the holding register only while `tx_empty_o` is 1, and `tx_empty_o` then falls. A write while the register is full is ignored.
- R5: `irq_tx_o` is high exactly while bit8 and `tx_empty_o` are both 1.
- R6: With loopback set, the transmit stream feeds the receiver, `tx_o` is held at 1 and `rx_i` has no effect.
- R7: With break set and loopback clear, `tx_o` takes the break-level bit from the next clock, overriding any frame in progress.
- R8: The receiver checks the start bit at its middle (8th tick) and samples every later bit at its middle. The receiver then sets `rx_ready_o` and presents the byte on `rx_data_o`, with bit7 at 0 in seven-bit mode. `rx_rd_i` clears `rx_ready_o`.
- R9: `irq_rx_o` is high exactly while bit9 and `rx_ready_o` are both 1.
- R10: `rx_err_o[2]` (parity) is set when the received parity bit does not match the selected parity. `rx_err_o[3]` (framing) is set when any stop bit is sampled at 0.
- R11: `rx_err_o[1]` (overrun) is set when a frame completes while `rx_ready_o` is still 1 and is not being read in that cycle. The new byte replaces the old one.
- R12: `rx_err_o[0]` (break) is set when every sampled bit of a frame, stop bits included, is 0. No byte is delivered, and reception resumes only after the line returns to 1.
- R13: Error flags stay set until `stat_rd_i` clears them. `irq_rs_o` is high exactly while bit10 is 1 and any error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Enable pulse, 16 per bit period |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 11 | Control word value |
| tx_wr_i | input | 1 | Write byte into the holding register |
| tx_data_i | input | 8 | Byte to transmit |
| tx_empty_o | output | 1 | Holding register empty |
| tx_o | output | 1 | Serial output line |
| rx_i | input | 1 | Serial input line (asynchronous) |
| rx_rd_i | input | 1 | Take received byte, clears data-ready |
| rx_data_o | output | 8 | Received byte |
| rx_ready_o | output | 1 | Received byte valid |
| stat_rd_i | input | 1 | Status read, clears error flags |
| rx_err_o | output | 4 | Sticky flags: [0] break, [1] overrun, [2] parity, [3] framing |
| irq_tx_o | output | 1 | Transmit-empty interrupt level |
| irq_rx_o | output | 1 | Receive-ready interrupt level |
| irq_rs_o | output | 1 | Receive-status interrupt level |

## Verification
A corrupted receiver state, such as a bad bit index or a wrong sampling phase, appears one frame later as a wrong byte on `rx_data_o` or as a spurious parity or framing flag. The loopback vectors expose it within about 200 ticks. A transmitter fault shows directly in the `tx_o` waveform, which is captured bit by bit at mid-bit. A fault in the holding or data-ready state shows within a cycle on `tx_empty_o`, `rx_ready_o` and the interrupt levels. Break and loopback overrides are checked at `tx_o` two clocks after the control write.

// File: rtl/uart_pkg.sv
package uart_pkg;

  typedef struct packed {
    logic       rs_ie;
    logic       rx_ie;
    logic       tx_ie;
    logic       loop;
    logic       brk_val;
    logic       brk;
    logic [1:0] parity;   // [1] enable, [0] even
    logic       stop2;
    logic       wlen8;
    logic       tx_en;
  } uart_cfg_t;

  localparam int CFG_W = $bits(uart_cfg_t);

  localparam int ERR_BRK = 0;
  localparam int ERR_OVR = 1;
  localparam int ERR_PAR = 2;
  localparam int ERR_FRM = 3;
  localparam int ERR_N   = 4;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_HOLD
  } rx_state_e;

endpackage

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  uart_cfg_t     cfg_i,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          empty_o,
  output logic          busy_o,
  output logic          ser_o
);

  localparam int FW = DW + 4;
  localparam int CW = $clog2(OSR);
  localparam int LW = $clog2(FW + 1);

  logic [DW-1:0] hold_q;
  logic          full_q;
  logic          busy_q;
  logic [FW-1:0] sh_q;
  logic [FW-1:0] frame;
  logic [LW-1:0] left_q;
  logic [LW-1:0] len;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] dmask;
  logic          start;
  logic          bit_end;
  int            nd;

  assign start   = full_q & ~busy_q & cfg_i.tx_en;
  assign bit_end = busy_q & tick_i & (cnt_q == CW'(OSR - 1));

  always_comb begin
    nd    = cfg_i.wlen8 ? DW : DW - 1;
    dmask = cfg_i.wlen8 ? hold_q : {1'b0, hold_q[DW-2:0]};
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < nd) frame[1+i] = dmask[i];
    end
    if (cfg_i.parity[1]) frame[1+nd] = (^dmask) ^ ~cfg_i.parity[0];
    len = LW'(nd + 2) + LW'(cfg_i.parity[1]) + LW'(cfg_i.stop2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_i && !full_q) begin
        hold_q <= data_i;
        full_q <= 1'b1;
      end else if (start) begin
        full_q <= 1'b0;
      end
      if (start) begin
        busy_q <= 1'b1;
        sh_q   <= frame;
        left_q <= len;
        cnt_q  <= '0;
      end else if (busy_q && tick_i) begin
        if (bit_end) begin
          cnt_q  <= '0;
          sh_q   <= {1'b1, sh_q[FW-1:1]};
          left_q <= left_q - LW'(1);
          if (left_q == LW'(1)) busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign empty_o = ~full_q;
  assign busy_o  = busy_q;
  assign ser_o   = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  uart_cfg_t        cfg_i,
  input  logic             line_i,
  input  logic             rd_i,
  input  logic             clr_i,
  output logic [DW-1:0]    data_o,
  output logic             ready_o,
  output logic [ERR_N-1:0] err_o,
  output logic             done_o
);

  localparam int BW  = DW + 3;
  localparam int CW  = $clog2(OSR);
  localparam int IW  = $clog2(BW);
  localparam int MID = OSR / 2 - 1;

  logic [1:0]       sync_q;
  logic             rx_s;
  rx_state_e        st_q;
  logic [CW-1:0]    cnt_q;
  logic [IW-1:0]    idx_q;
  logic [BW-1:0]    bits_q;
  logic [BW-1:0]    fv;
  logic [BW-1:0]    lmask;
  logic [DW-1:0]    dm;
  logic [DW-1:0]    data_q;
  logic             ready_q;
  logic [ERR_N-1:0] err_q;
  logic [ERR_N-1:0] err_set;
  logic             all_zero, par_bad, frm_bad, last, done, good;
  int               nd, need, sp;

  assign rx_s = sync_q[1];

  always_comb begin
    nd   = cfg_i.wlen8 ? DW : DW - 1;
    sp   = nd + int'(cfg_i.parity[1]);
    need = sp + 1 + int'(cfg_i.stop2);
    fv   = bits_q;
    fv[idx_q] = rx_s;
    dm   = cfg_i.wlen8 ? fv[DW-1:0] : {1'b0, fv[DW-2:0]};
    lmask = '0;
    for (int i = 0; i < BW; i++) begin
      if (i < need) lmask[i] = 1'b1;
    end
    all_zero = ((fv & lmask) == '0);
    frm_bad  = ~fv[sp] | (cfg_i.stop2 & ~fv[sp+1]);
    par_bad  = cfg_i.parity[1] & (fv[nd] != ((^dm) ^ ~cfg_i.parity[0]));
    last     = (idx_q == IW'(need - 1));
  end

  assign done = tick_i & (st_q == RX_BITS) & (cnt_q == CW'(OSR - 1)) & last;
  assign good = done & ~all_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      bits_q <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (tick_i) begin
        unique case (st_q)
          RX_IDLE: begin
            if (!rx_s) begin
              st_q  <= RX_START;
              cnt_q <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == CW'(MID)) begin
              cnt_q  <= '0;
              idx_q  <= '0;
              bits_q <= '0;
              st_q   <= rx_s ? RX_IDLE : RX_BITS;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          RX_BITS: begin
            if (cnt_q == CW'(OSR - 1)) begin
              cnt_q  <= '0;
              bits_q <= fv;
              idx_q  <= idx_q + IW'(1);
              if (last) st_q <= all_zero ? RX_HOLD : RX_IDLE;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          RX_HOLD: begin
            if (rx_s) st_q <= RX_IDLE;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ready_q <= 1'b0;
    end else if (good) begin
      data_q  <= dm;
      ready_q <= 1'b1;
    end else if (rd_i) begin
      ready_q <= 1'b0;
    end
  end

  always_comb begin
    err_set          = '0;
    err_set[ERR_BRK] = done & all_zero;
    err_set[ERR_OVR] = good & ready_q & ~rd_i;
    err_set[ERR_PAR] = good & par_bad;
    err_set[ERR_FRM] = good & frm_bad;
  end

  for (genvar g = 0; g < ERR_N; g++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         err_q[g] <= 1'b0;
      else if (err_set[g]) err_q[g] <= 1'b1;
      else if (clr_i)      err_q[g] <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign ready_o = ready_q;
  assign err_o   = err_q;
  assign done_o  = done;

endmodule

// File: rtl/uart_port.sv
module uart_port
  import uart_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             baud_tick_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             tx_wr_i,
  input  logic [DW-1:0]    tx_data_i,
  output logic             tx_empty_o,
  output logic             tx_o,
  input  logic             rx_i,
  input  logic             rx_rd_i,
  output logic [DW-1:0]    rx_data_o,
  output logic             rx_ready_o,
  input  logic             stat_rd_i,
  output logic [ERR_N-1:0] rx_err_o,
  output logic             irq_tx_o,
  output logic             irq_rx_o,
  output logic             irq_rs_o
);

  uart_cfg_t cfg_q;
  logic      tx_ser, tx_busy, line_int, rx_line, tx_q, rx_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= uart_cfg_t'(cfg_wdata_i);
  end

  uart_tx #(.DW(DW), .OSR(OSR)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .cfg_i   (cfg_q),
    .wr_i    (tx_wr_i),
    .data_i  (tx_data_i),
    .empty_o (tx_empty_o),
    .busy_o  (tx_busy),
    .ser_o   (tx_ser)
  );

  assign line_int = cfg_q.brk ? cfg_q.brk_val : tx_ser;
  assign rx_line  = cfg_q.loop ? line_int : rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= 1'b1;
    else         tx_q <= cfg_q.loop ? 1'b1 : line_int;
  end
  assign tx_o = tx_q;

  uart_rx #(.DW(DW), .OSR(OSR)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .cfg_i   (cfg_q),
    .line_i  (rx_line),
    .rd_i    (rx_rd_i),
    .clr_i   (stat_rd_i),
    .data_o  (rx_data_o),
    .ready_o (rx_ready_o),
    .err_o   (rx_err_o),
    .done_o  (rx_done)
  );

  assign irq_tx_o = cfg_q.tx_ie & tx_empty_o;
  assign irq_rx_o = cfg_q.rx_ie & rx_ready_o;
  assign irq_rs_o = cfg_q.rs_ie & (|rx_err_o);

endmodule

// File: rtl/uart_port_chk.sv
module uart_port_chk
  import uart_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input uart_cfg_t        cfg_q,
  input logic             tx_o,
  input logic             tx_wr_i,
  input logic             tx_empty_o,
  input logic             tx_busy,
  input logic             rx_rd_i,
  input logic             rx_ready_o,
  input logic             rx_done,
  input logic             stat_rd_i,
  input logic [ERR_N-1:0] rx_err_o
);

  // R6
  loop_pin_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.loop |=> tx_o);

  // R7
  brk_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.brk && !cfg_q.loop) |=> (tx_o == $past(cfg_q.brk_val)));

  // R3
  tx_hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.tx_en && !tx_busy) |=> !tx_busy);

  // R4
  hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && tx_empty_o) |=> !tx_empty_o);

  // R8
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && !rx_done) |=> !rx_ready_o);

  // R11
  ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_err_o[ERR_OVR]) |-> $past(rx_ready_o));

  // R13
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> ((rx_err_o & $past(rx_err_o)) == $past(rx_err_o)));

endmodule

bind uart_port uart_port_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_q      (cfg_q),
  .tx_o       (tx_o),
  .tx_wr_i    (tx_wr_i),
  .tx_empty_o (tx_empty_o),
  .tx_busy    (tx_busy),
  .rx_rd_i    (rx_rd_i),
  .rx_ready_o (rx_ready_o),
  .rx_done    (rx_done),
  .stat_rd_i  (stat_rd_i),
  .rx_err_o   (rx_err_o)
);

// File: tb/test_uart_port.sv
module test_uart_port;

  localparam logic [10:0] C_TXEN = 11'h001;
  localparam logic [10:0] C_WL8  = 11'h002;
  localparam logic [10:0] C_ST2  = 11'h004;
  localparam logic [10:0] C_PODD = 11'h010;
  localparam logic [10:0] C_PEVN = 11'h018;
  localparam logic [10:0] C_BRK  = 11'h020;
  localparam logic [10:0] C_BVAL = 11'h040;
  localparam logic [10:0] C_LOOP = 11'h080;
  localparam logic [10:0] C_TXIE = 11'h100;
  localparam logic [10:0] C_RXIE = 11'h200;
  localparam logic [10:0] C_RSIE = 11'h400;
  localparam int BIT_CYC = 32;  // 16 ticks, one tick every 2 clocks

  // {format bits, data written, byte expected}
  localparam int NV = 7;
  localparam logic [26:0] VEC [NV] = '{
    {C_WL8,                 8'hA5, 8'hA5},
    {11'h000,               8'hC3, 8'h43},
    {C_WL8 | C_PODD,        8'h0F, 8'h0F},
    {C_WL8 | C_PEVN | C_ST2, 8'h81, 8'h81},
    {C_PEVN | C_ST2,        8'hFF, 8'h7F},
    {C_PODD,                8'h00, 8'h00},
    {C_WL8 | C_ST2,         8'h3C, 8'h3C}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cfg_we = 1'b0;
  logic [10:0] cfg_wd = '0;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_d = '0;
  logic        tx_empty, tx_line, rx_ready, irq_tx, irq_rx, irq_rs;
  logic        rx_line = 1'b1;
  logic        rx_rd = 1'b0;
  logic        st_rd = 1'b0;
  logic [7:0]  rx_d;
  logic [3:0]  err;
  int          checks = 0;
  int          fails = 0;
  bit          over = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;
  end

  uart_port i_uart_port (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .baud_tick_i (tick),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wd),
    .tx_wr_i     (tx_wr),
    .tx_data_i   (tx_d),
    .tx_empty_o  (tx_empty),
    .tx_o        (tx_line),
    .rx_i        (rx_line),
    .rx_rd_i     (rx_rd),
    .rx_data_o   (rx_d),
    .rx_ready_o  (rx_ready),
    .stat_rd_i   (st_rd),
    .rx_err_o    (err),
    .irq_tx_o    (irq_tx),
    .irq_rx_o    (irq_rx),
    .irq_rs_o    (irq_rs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [10:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wd = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_d = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic pulse_st();
    @(negedge clk); st_rd = 1'b1;
    @(negedge clk); st_rd = 1'b0;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 3000 && !rx_ready; k++) @(negedge clk);
  endtask

  task automatic drive_rx(input logic [11:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      rx_line = v[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
  endtask

  task automatic capture(output logic [11:0] v, input int n);
    v = '1;
    for (int k = 0; k < 3000 && tx_line; k++) @(negedge clk);
    repeat (BIT_CYC / 2) @(negedge clk);
    v[0] = tx_line;
    for (int i = 1; i < n; i++) begin
      repeat (BIT_CYC) @(negedge clk);
      v[i] = tx_line;
    end
  endtask

  function automatic logic [11:0] frame_of(input logic [7:0] d, input bit wl8,
                                           input logic [1:0] par, input bit st2,
                                           output int n);
    logic [11:0] f;
    int nd;
    logic ones;
    nd = wl8 ? 8 : 7;
    f = '1;
    f[0] = 1'b0;
    ones = 1'b0;
    for (int i = 0; i < nd; i++) begin
      f[1+i] = d[i];
      ones ^= d[i];
    end
    n = 1 + nd;
    if (par[1]) begin
      f[n] = par[0] ? ones : ~ones;
      n++;
    end
    n = n + 1 + int'(st2);
    return f;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!over) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [11:0] cap;
    logic [11:0] ef;
    int          n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_o", tx_line, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 err", err, 0);
    chk("R1 irqs", {irq_tx, irq_rx, irq_rs}, 0);

    // R5 transmit irq level
    set_cfg(C_TXIE);
    @(negedge clk);
    chk("R5 irq_tx empty", irq_tx, 1);

    // R3, R4 holding register while transmitter disabled
    send(8'h5A);
    chk("R4 tx_empty after write", tx_empty, 0);
    chk("R5 irq_tx full", irq_tx, 0);
    send(8'h33);
    repeat (20 * BIT_CYC) @(negedge clk);
    chk("R3 tx_o idle while disabled", tx_line, 1);
    chk("R3 byte held", tx_empty, 0);

    // R6 loopback, rx_i driven low must not matter; R4 second write ignored
    rx_line = 1'b0;
    set_cfg(C_LOOP | C_TXEN | C_WL8);
    repeat (4 * BIT_CYC) @(negedge clk);
    chk("R6 tx_o high in loopback", tx_line, 1);
    wait_ready();
    chk("R4 first byte kept", rx_d, 8'h5A);
    chk("R6 loopback no error", err, 0);
    rx_line = 1'b1;
    pulse_rd();
    chk("R8 rd clears ready", rx_ready, 0);

    // R2, R6, R8 loopback format table
    for (int v = 0; v < NV; v++) begin
      set_cfg(C_LOOP | C_TXEN | VEC[v][26:16]);
      send(VEC[v][15:8]);
      wait_ready();
      chk($sformatf("R8 loop vec%0d data", v), rx_d, VEC[v][7:0]);
      chk($sformatf("R2 loop vec%0d err", v), err, 0);
      pulse_rd();
      repeat (2 * BIT_CYC) @(negedge clk);
    end

    // R2 transmitted waveform
    set_cfg(C_TXEN | C_WL8 | C_PODD | C_ST2);
    ef = frame_of(8'hB4, 1'b1, 2'b10, 1'b1, n);
    send(8'hB4);
    capture(cap, n);
    chk("R2 frame 8O2", cap, ef);
    repeat (3 * BIT_CYC) @(negedge clk);
    set_cfg(C_TXEN | C_PEVN);
    ef = frame_of(8'h6D, 1'b0, 2'b11, 1'b0, n);
    send(8'h6D);
    capture(cap, n);
    chk("R2 frame 7E1", cap, ef);
    repeat (3 * BIT_CYC) @(negedge clk);

    // R7 break level
    set_cfg(C_BRK);
    @(negedge clk);
    chk("R7 break low", tx_line, 0);
    set_cfg(C_BRK | C_BVAL);
    @(negedge clk);
    chk("R7 break high", tx_line, 1);
    set_cfg(C_TXEN | C_WL8);
    send(8'h00);
    for (int k = 0; k < 3000 && tx_line; k++) @(negedge clk);
    repeat (3 * BIT_CYC) @(negedge clk);
    chk("R7 data bit low before break", tx_line, 0);
    set_cfg(C_TXEN | C_WL8 | C_BRK | C_BVAL);
    @(negedge clk);
    chk("R7 break overrides frame", tx_line, 1);
    set_cfg(C_TXEN | C_WL8);
    repeat (12 * BIT_CYC) @(negedge clk);

    // R8, R9 external reception
    set_cfg(C_WL8 | C_RXIE | C_RSIE);
    ef = frame_of(8'h96, 1'b1, 2'b00, 1'b0, n);
    drive_rx(ef, n);
    chk("R8 ext data", rx_d, 8'h96);
    chk("R9 irq_rx high", irq_rx, 1);
    pulse_rd();
    chk("R9 irq_rx low after read", irq_rx, 0);

    // R11 overrun
    ef = frame_of(8'h11, 1'b1, 2'b00, 1'b0, n);
    drive_rx(ef, n);
    ef = frame_of(8'h22, 1'b1, 2'b00, 1'b0, n);
    drive_rx(ef, n);
    chk("R11 overrun flag", err, 4'b0010);
    chk("R11 newer byte", rx_d, 8'h22);
    chk("R13 irq_rs on error", irq_rs, 1);
    pulse_st();
    chk("R13 status read clears", err, 0);
    chk("R13 irq_rs cleared", irq_rs, 0);
    pulse_rd();

    // R10 parity error: even parity, wrong parity bit
    set_cfg(C_WL8 | C_PEVN | C_RSIE);
    drive_rx(12'b1_0_00000001_0, 11);
    chk("R10 parity flag", err, 4'b0100);
    chk("R10 byte still delivered", rx_d, 8'h01);
    pulse_rd();
    pulse_st();

    // R10 framing error: stop bit low
    set_cfg(C_WL8 | C_RSIE);
    drive_rx(12'b0_10000000_0, 10);
    chk("R10 framing flag", err[3], 1);
    repeat (14 * BIT_CYC) @(negedge clk);
    pulse_rd();
    pulse_st();
    repeat (2) @(negedge clk);
    chk("R13 cleared after framing", err, 0);

    // R12 break detection
    drive_rx(12'h000, 10);
    chk("R12 break flag only", err, 4'b0001);
    chk("R12 no byte delivered", rx_ready, 0);
    chk("R13 irq_rs on break", irq_rs, 1);
    pulse_st();
    ef = frame_of(8'h5C, 1'b1, 2'b00, 1'b0, n);
    drive_rx(ef, n);
    chk("R12 reception resumes", rx_d, 8'h5C);
    chk("R12 resume no error", err, 0);

    over = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule